// File: doc/BRIEF.md
# Bandwidth-Budgeted Test Core Activation Arbiter

This block decides which idle cores may start or resume testing on a shared test bus. The bus has a fixed bandwidth budget. Each core presents five values: a ready flag, its count of remaining test patterns, a defect-likelihood weight, its present temperature and the bus bandwidth its test needs. The block does not model temperature, generate patterns or estimate test time; all of these arrive as inputs.

An activation pass starts when a request is accepted on a valid/ready handshake. The candidates are the cores that are ready and not already active. The block ranks them by a score: remaining patterns times defect weight, divided by temperature. Scores are compared by cross-multiplying, so no divider is needed. Cores are granted one per cycle, best score first. Granting stops as soon as the free budget is zero, no candidate remains, or the best remaining candidate does not fit.

Each grant takes the core's bandwidth out of the budget, marks the core active and pulses its activate line. The pass ends with a single-cycle done pulse carrying the grant mask. A release mask hands bandwidth back when cores leave the active state.

The request interface has no downstream back-pressure. `req_ready` is low for the whole pass, and a request presented then simply waits. The done pulse has no ready signal and must be captured in the cycle it appears.

Top module: `core_activation_arbiter`

## Requirements
- R1: The candidates of a pass are the cores with `core_ready` set and `active` clear at the cycle the request is accepted. A core that is already active is never granted again.
- R2: Candidates are granted in descending order of remaining × weight / temperature. Core i's fields sit at bits [i*W +: W] of each packed input. On equal scores the lower core index is granted first.
- R3: A pass stops granting when `free_bw` is zero or no candidate remains.
- R4: If the best remaining candidate needs more bandwidth than `free_bw`, the pass ends at once, and no lower-ranked core is granted in that pass.
- R5: A grant subtracts the core's need from `free_bw` and sets its `active` bit. It also raises its `activate` bit for exactly one cycle. At most one `activate` bit is high in any cycle.
- R6: `free_bw` never exceeds BUS_LIMIT. The bandwidth held by active cores plus `free_bw` always equals BUS_LIMIT.
- R7: `release_mask` clears the listed active cores and returns the bandwidth each of them was granted. Bits for inactive cores have no effect. A release and a grant in the same cycle are both applied to `free_bw`.
- R8: `req_ready` is high only between passes. A pass lasts at most NUM_CORES+1 cycles after acceptance. It ends with a one-cycle `done` pulse, and `grant_mask` then holds the set granted in that pass.
- R9: After reset `free_bw` equals BUS_LIMIT, `active` is zero, `done` and `activate` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request to run an activation pass |
| req_ready | output | 1 | High when a pass can be accepted |
| core_ready | input | NUM_CORES | Per-core ready-for-test flag |
| remaining | input | NUM_CORES*CNT_W | Remaining pattern count per core |
| defect_wt | input | NUM_CORES*WT_W | Defect-likelihood weight per core |
| temperature | input | NUM_CORES*TMP_W | Present temperature per core (nonzero) |
| bw_need | input | NUM_CORES*BW_W | Bus bandwidth each core needs |
| release_mask | input | NUM_CORES | Cores leaving the active state this cycle |
| done | output | 1 | One-cycle pulse at the end of a pass |
| grant_mask | output | NUM_CORES | Cores granted in the last pass |
| activate | output | NUM_CORES | One-cycle pulse per granted core |
| active | output | NUM_CORES | Cores currently holding bandwidth |
| free_bw | output | BW_W | Bandwidth still free on the bus |

## Verification
The assertions take three things for granted about the inputs:
- each core's bandwidth need is at most BUS_LIMIT;
- temperatures are nonzero;
- the ranking inputs are held stable from the accepted request until `done`.

Release bits may arrive at any time. The stimulus changes the per-core fields only between passes and keeps every need within the budget. Its one deliberate overlap drives a release in the same cycle as a grant, to exercise the combined budget update.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [0:0] {
    S_IDLE = 1'b0,
    S_SCAN = 1'b1
  } arb_state_t;
endpackage

// File: rtl/arb_rank.sv
module arb_rank #(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 8,
  parameter int WT_W      = 8,
  parameter int TMP_W     = 8,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [NUM_CORES-1:0]       cand,
  input  logic [NUM_CORES*CNT_W-1:0] remaining,
  input  logic [NUM_CORES*WT_W-1:0]  defect_wt,
  input  logic [NUM_CORES*TMP_W-1:0] temperature,
  output logic                       found,
  output logic [IDX_W-1:0]           best
);
  localparam int WL_W = CNT_W + WT_W;
  localparam int XP_W = WL_W + TMP_W;

  logic [WL_W-1:0]  workload [NUM_CORES];
  logic [TMP_W-1:0] temp_c   [NUM_CORES];

  // Numerator of each score: remaining patterns times defect weight.
  for (genvar g = 0; g < NUM_CORES; g++) begin : g_wl
    assign workload[g] = WL_W'(remaining[g*CNT_W +: CNT_W]) *
                         WL_W'(defect_wt[g*WT_W +: WT_W]);
    assign temp_c[g]   = temperature[g*TMP_W +: TMP_W];
  end

  // Linear scan. A core replaces the current best only on a strictly
  // larger score (R2), so on a tie the lower index is kept.
  always_comb begin
    logic [XP_W-1:0] lhs;
    logic [XP_W-1:0] rhs;
    found = 1'b0;
    best  = '0;
    lhs   = '0;
    rhs   = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (cand[i]) begin
        lhs = XP_W'(workload[i]) * XP_W'(temp_c[best]);
        rhs = XP_W'(workload[best]) * XP_W'(temp_c[i]);
        if (!found || (lhs > rhs)) begin
          best  = IDX_W'(i);
          found = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/arb_ledger.sv
module arb_ledger #(
  parameter int NUM_CORES = 4,
  parameter int BW_W      = 6,
  parameter int BUS_LIMIT = 16,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SUM_W    = BW_W + IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grant_en,
  input  logic [IDX_W-1:0]     grant_idx,
  input  logic [BW_W-1:0]      grant_bw,
  input  logic [NUM_CORES-1:0] release_mask,
  output logic [NUM_CORES-1:0] active,
  output logic [BW_W-1:0]      free_bw
);
  logic [BW_W-1:0]      held [NUM_CORES];
  logic [NUM_CORES-1:0] eff_rel;
  logic [SUM_W-1:0]     rel_sum;
  logic [SUM_W-1:0]     held_sum;
  logic [SUM_W-1:0]     free_next;

  // Release bits of inactive cores are dropped (R7).
  assign eff_rel = release_mask & active;

  always_comb begin
    rel_sum  = '0;
    held_sum = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (eff_rel[i]) rel_sum  = rel_sum + SUM_W'(held[i]);
      if (active[i])  held_sum = held_sum + SUM_W'(held[i]);
    end
    // Grant and release in the same cycle are both applied (R7).
    free_next = SUM_W'(free_bw) + rel_sum - (grant_en ? SUM_W'(grant_bw) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_bw <= BW_W'(BUS_LIMIT);
      active  <= '0;
      for (int i = 0; i < NUM_CORES; i++) held[i] <= '0;
    end else begin
      free_bw <= BW_W'(free_next);
      for (int i = 0; i < NUM_CORES; i++) begin
        if (grant_en && (grant_idx == IDX_W'(i))) begin
          active[i] <= 1'b1;
          held[i]   <= grant_bw;
        end else if (eff_rel[i]) begin
          active[i] <= 1'b0;
          held[i]   <= '0;
        end
      end
    end
  end

  // R6: the budget is conserved between free and held bandwidth.
  p_budget_conserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (SUM_W'(free_bw) + held_sum) == SUM_W'(BUS_LIMIT));
  p_free_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    SUM_W'(free_bw) <= SUM_W'(BUS_LIMIT));
  // R4: a grant never takes more than is free.
  p_grant_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_en |-> (grant_bw <= free_bw));
  // R5: a granted core is active afterwards.
  p_grant_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_en |=> active[$past(grant_idx)]);
endmodule

// File: rtl/core_activation_arbiter.sv
module core_activation_arbiter #(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 8,
  parameter int WT_W      = 8,
  parameter int TMP_W     = 8,
  parameter int BW_W      = 6,
  parameter int BUS_LIMIT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [NUM_CORES-1:0]       core_ready,
  input  logic [NUM_CORES*CNT_W-1:0] remaining,
  input  logic [NUM_CORES*WT_W-1:0]  defect_wt,
  input  logic [NUM_CORES*TMP_W-1:0] temperature,
  input  logic [NUM_CORES*BW_W-1:0]  bw_need,
  input  logic [NUM_CORES-1:0]       release_mask,
  output logic                       done,
  output logic [NUM_CORES-1:0]       grant_mask,
  output logic [NUM_CORES-1:0]       activate,
  output logic [NUM_CORES-1:0]       active,
  output logic [BW_W-1:0]            free_bw
);
  import arb_pkg::*;
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int CYC_W = $clog2(NUM_CORES + 3);

  arb_state_t           state;
  logic [NUM_CORES-1:0] cand;
  logic [NUM_CORES-1:0] acc;
  logic                 found;
  logic [IDX_W-1:0]     best;
  logic [BW_W-1:0]      need_best;
  logic                 grant_now;
  logic                 finish;
  logic [CYC_W-1:0]     pass_cyc;

  arb_rank #(
    .NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .WT_W(WT_W), .TMP_W(TMP_W)
  ) i_rank (
    .cand(cand), .remaining(remaining), .defect_wt(defect_wt),
    .temperature(temperature), .found(found), .best(best)
  );

  assign need_best = bw_need[best*BW_W +: BW_W];
  // Stop on empty set, empty budget or first misfit (R3, R4).
  assign grant_now = (state == S_SCAN) && found && (free_bw != '0) &&
                     (need_best <= free_bw);
  assign finish    = (state == S_SCAN) && !grant_now;
  assign req_ready = (state == S_IDLE);

  arb_ledger #(
    .NUM_CORES(NUM_CORES), .BW_W(BW_W), .BUS_LIMIT(BUS_LIMIT)
  ) i_ledger (
    .clk(clk), .rst_n(rst_n), .grant_en(grant_now), .grant_idx(best),
    .grant_bw(need_best), .release_mask(release_mask),
    .active(active), .free_bw(free_bw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cand       <= '0;
      acc        <= '0;
      done       <= 1'b0;
      grant_mask <= '0;
      activate   <= '0;
      pass_cyc   <= '0;
    end else begin
      done     <= 1'b0;
      activate <= '0;
      if (state == S_IDLE) begin
        if (req_valid) begin
          cand     <= core_ready & ~active;   // R1
          acc      <= '0;
          pass_cyc <= '0;
          state    <= S_SCAN;
        end
      end else begin
        pass_cyc <= pass_cyc + 1'b1;
        if (grant_now) begin
          cand[best]     <= 1'b0;
          acc[best]      <= 1'b1;
          activate[best] <= 1'b1;
        end
        if (finish) begin
          done       <= 1'b1;
          grant_mask <= acc;
          state      <= S_IDLE;
        end
      end
    end
  end

  // R1: only an inactive candidate is granted.
  p_grant_candidate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_now |-> (cand[best] && !active[best]));
  // R5: activation pulses are one-hot and last one cycle.
  p_activate_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(activate));
  p_activate_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (activate != '0) |=> ((activate & $past(activate)) == '0));
  // R4: a misfit at the top of the ranking ends the pass next cycle.
  p_misfit_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_SCAN) && found && (need_best > free_bw)) |=> done);
  // R8: done is a single pulse and the pass length is bounded.
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_pass_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SCAN) |-> (pass_cyc <= CYC_W'(NUM_CORES)));
endmodule

// File: tb/test_core_activation_arbiter.sv
module test_core_activation_arbiter;
  localparam int N = 4;
  localparam int LIMIT = 16;

  typedef struct packed {
    logic [3:0]  rdy;
    logic [31:0] rem;
    logic [31:0] wt;
    logic [31:0] tmp;
    logic [23:0] need;
    logic [3:0]  exp_mask;
    logic [7:0]  exp_order;
    logic [2:0]  exp_cnt;
    logic [5:0]  exp_free;
  } vec_t;

  // Fields packed core3..core0; order packed {4th,3rd,2nd,1st}.
  localparam vec_t VEC [7] = '{
    '{4'hF, {8'd10,8'd10,8'd10,8'd10}, {8'd4,8'd3,8'd2,8'd1}, {8'd10,8'd10,8'd10,8'd10},
      {6'd4,6'd4,6'd4,6'd4}, 4'hF, {2'd0,2'd1,2'd2,2'd3}, 3'd4, 6'd0},
    '{4'hF, {8'd5,8'd5,8'd5,8'd5}, {8'd5,8'd5,8'd5,8'd5}, {8'd20,8'd20,8'd20,8'd20},
      {6'd5,6'd5,6'd5,6'd5}, 4'h7, {2'd0,2'd2,2'd1,2'd0}, 3'd3, 6'd1},
    '{4'hF, {8'd10,8'd20,8'd50,8'd100}, {8'd1,8'd1,8'd1,8'd1}, {8'd10,8'd10,8'd10,8'd10},
      {6'd1,6'd2,6'd8,6'd12}, 4'h1, {2'd0,2'd0,2'd0,2'd0}, 3'd1, 6'd4},
    '{4'hF, {8'd20,8'd20,8'd20,8'd20}, {8'd2,8'd2,8'd2,8'd2}, {8'd20,8'd80,8'd10,8'd40},
      {6'd6,6'd6,6'd6,6'd6}, 4'hA, {2'd0,2'd0,2'd3,2'd1}, 3'd2, 6'd4},
    '{4'h5, {8'd200,8'd50,8'd200,8'd1}, {8'd1,8'd1,8'd1,8'd1}, {8'd10,8'd10,8'd10,8'd10},
      {6'd2,6'd2,6'd2,6'd2}, 4'h5, {2'd0,2'd0,2'd0,2'd2}, 3'd2, 6'd12},
    '{4'h0, {8'd1,8'd1,8'd1,8'd1}, {8'd1,8'd1,8'd1,8'd1}, {8'd1,8'd1,8'd1,8'd1},
      {6'd1,6'd1,6'd1,6'd1}, 4'h0, 8'd0, 3'd0, 6'd16},
    '{4'hF, {8'd1,8'd1,8'd1,8'd9}, {8'd1,8'd1,8'd1,8'd1}, {8'd1,8'd1,8'd1,8'd1},
      {6'd1,6'd1,6'd1,6'd16}, 4'h1, 8'd0, 3'd1, 6'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [N-1:0] core_ready = '0;
  logic [N*8-1:0] remaining = '0;
  logic [N*8-1:0] defect_wt = '0;
  logic [N*8-1:0] temperature = '1;
  logic [N*6-1:0] bw_need = '0;
  logic [N-1:0] release_mask = '0;
  logic done;
  logic [N-1:0] grant_mask;
  logic [N-1:0] activate;
  logic [N-1:0] active;
  logic [5:0] free_bw;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  logic [7:0] got_order;
  int got_cnt;
  int pass_len;

  always #2.5 clk = ~clk;

  core_activation_arbiter i_core_activation_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .core_ready(core_ready), .remaining(remaining), .defect_wt(defect_wt),
    .temperature(temperature), .bw_need(bw_need), .release_mask(release_mask),
    .done(done), .grant_mask(grant_mask), .activate(activate),
    .active(active), .free_bw(free_bw)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic release_cores(input logic [N-1:0] m);
    @(negedge clk) release_mask = m;
    @(negedge clk) release_mask = '0;
  endtask

  task automatic wait_done();
    got_order = '0;
    got_cnt = 0;
    pass_len = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      pass_len++;
      for (int c = 0; c < N; c++)
        if (activate[c]) begin
          got_order[got_cnt*2 +: 2] = 2'(c);
          got_cnt++;
        end
      if (done) break;
    end
  endtask

  task automatic start_pass();
    @(negedge clk) req_valid = 1'b1;
    @(negedge clk) req_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 free", free_bw, LIMIT);
    check("R9 active", active, 0);
    check("R9 ready", req_ready, 1);
    check("R9 done", done, 0);

    for (int v = 0; v < 7; v++) begin
      release_cores('1);
      core_ready = VEC[v].rdy;
      remaining = VEC[v].rem;
      defect_wt = VEC[v].wt;
      temperature = VEC[v].tmp;
      bw_need = VEC[v].need;
      @(negedge clk) req_valid = 1'b1;
      @(negedge clk) req_valid = 1'b0;
      check("R8 busy", req_ready, 0);
      wait_done();
      // R2 order, R3/R4 stop point, R5 budget, R8 mask
      check("R2 order", got_order, VEC[v].exp_order);
      check("R5 count", got_cnt, VEC[v].exp_cnt);
      check("R4 mask", grant_mask, VEC[v].exp_mask);
      check("R3 free", free_bw, VEC[v].exp_free);
      check("R8 length", (pass_len <= N + 1), 1);
    end

    // R1: active core is not a candidate again
    release_cores('1);
    core_ready = 4'hF;
    remaining = {8'd10,8'd20,8'd50,8'd100};
    defect_wt = {8'd1,8'd1,8'd1,8'd1};
    temperature = {8'd10,8'd10,8'd10,8'd10};
    bw_need = {6'd1,6'd2,6'd8,6'd12};
    start_pass(); wait_done();
    bw_need = {6'd1,6'd2,6'd4,6'd12};
    start_pass(); wait_done();
    check("R1 mask", grant_mask, 4'h2);
    check("R1 free", free_bw, 0);
    // R7: release of an inactive core is ignored
    release_cores(4'h4);
    check("R7 ignore free", free_bw, 0);
    check("R7 ignore active", active, 4'h3);

    // R7: release in the same cycle as a grant
    release_cores('1);
    bw_need = {6'd1,6'd2,6'd8,6'd12};
    start_pass(); wait_done();
    bw_need = {6'd1,6'd2,6'd4,6'd12};
    @(negedge clk) req_valid = 1'b1;
    @(negedge clk) begin req_valid = 1'b0; release_mask = 4'h1; end
    wait_done();
    release_mask = '0;
    check("R7 same-cycle mask", grant_mask, 4'hE);
    check("R7 same-cycle free", free_bw, 9);
    check("R6 active", active, 4'hE);
    check("R5 first", got_order[1:0], 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule